// File: doc/BRIEF.md
# Multi-Cycle Hardwired Instruction Sequencer

This block is the control half of a small three-bus processor. It presents a program counter to a read-only instruction store and receives a 32-bit word back in the same cycle. The top four bits of that word select an instruction kind. From the kind, and from a small phase counter, hardwired logic produces three things each cycle: a 16-bit control word for the datapath, a 32-bit immediate value, and the next program counter.

The control word has four 4-bit fields. Bits 15:12 hold the ALU operation (A = pass bus 1, B = pass bus 2). Bits 11:8 select the bus 1 source and bits 7:4 select the bus 2 source. Bits 3:0 name the destination that loads the bus 3 result. Destination 12 is the RAM address register and destination 13 is the RAM data register. Source 11 on bus 1 is the immediate, and source 13 on bus 1 is the RAM read data.

Memory instructions take two cycles. The first cycle moves an address into the RAM address register. The second cycle moves the data. All other kinds finish in one cycle.

Top module: `instr_sequencer`

## Requirements
- R1: While reset is asserted, the control word and the immediate are zero and the program counter is 0. The first instruction executed after reset is the word at address 0.
- R2: For kind 0 (bits 31:28 = 0), bits 15:0 of the instruction are issued unchanged as the control word for one cycle, and the program counter then increments by one.
- R3: For kind 1, the immediate output is bits 27:4 sign-extended to 32 bits. The control word is operation A, bus 1 source 11, bus 2 source 0, and the destination from bits 3:0. This lasts one cycle, then the program counter increments.
- R4: For kind 3 (store), the first cycle issues operation B, bus 2 source from bits 7:4, and destination 12, while the program counter holds. The second cycle issues operation A, bus 1 source from bits 11:8, and destination 13. The program counter then increments.
- R5: For kind 2 (load), the first cycle issues operation A, bus 1 source from bits 11:8, and destination 12, while the program counter holds. The second cycle issues operation A, bus 1 source 13, and the destination from bits 3:0. The program counter then increments.
- R6: For kind F, the control word is zero and the next program counter is bits 27:0 of the instruction, zero-extended.
- R7: For any other kind, the control word and the immediate are zero, and the program counter increments.
- R8: The seven-word loop program 1FFFFFF9, 1FFFFFA1, 30000110, 20000103, 000051F2, 0000A201, F0000002 drives a datapath that stores an increasing count k into RAM word k, where the address is the low 8 bits of k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_pc | output | PC_W | Program counter, which is also the instruction store address |
| fetch_word | input | 32 | Instruction word read at fetch_pc |
| ctl_word | output | 16 | Datapath control word: operation, bus 1 source, bus 2 source, destination |
| imm_out | output | 32 | Extended immediate for kind 1, zero otherwise |

## Verification
In the last phase of a memory instruction, two things happen on the same clock edge: the data-transfer control word is issued, and the program counter advances while the phase counter clears. The next fetched instruction must therefore begin again at its own first phase. The bench provokes this by placing a store directly before a load, which is itself followed by a jump. It then compares the control word and the program counter in every cycle against the expected sequence. Finally, a datapath model in the bench runs the loop program, and the memory contents it produces confirm that no phase was skipped or repeated.

// File: rtl/seq_pkg.sv
package seq_pkg;
   localparam int unsigned INSN_W  = 32;
   localparam int unsigned CTL_W   = 16;
   localparam int unsigned IMM_W   = 32;
   localparam int unsigned IMM_FLD = 24;

   localparam logic [3:0] K_EXEC  = 4'h0;
   localparam logic [3:0] K_LDI   = 4'h1;
   localparam logic [3:0] K_LOAD  = 4'h2;
   localparam logic [3:0] K_STORE = 4'h3;
   localparam logic [3:0] K_JUMP  = 4'hF;

   localparam logic [3:0] OP_PASS_A = 4'hA;
   localparam logic [3:0] OP_PASS_B = 4'hB;
   localparam logic [3:0] SRC_NONE  = 4'h0;
   localparam logic [3:0] SRC_IMM   = 4'hB;
   localparam logic [3:0] SRC_MEM   = 4'hD;
   localparam logic [3:0] DST_ADDR  = 4'hC;
   localparam logic [3:0] DST_DATA  = 4'hD;

   typedef enum logic [1:0] {PC_HOLD, PC_STEP, PC_LOAD} pc_act_e;

   function automatic logic [CTL_W-1:0] pack_ctl(input logic [3:0] op,
                                                 input logic [3:0] s1,
                                                 input logic [3:0] s2,
                                                 input logic [3:0] dst);
      return {op, s1, s2, dst};
   endfunction
endpackage

// File: rtl/seq_pc.sv
module seq_pc
   import seq_pkg::*;
#(
   parameter int unsigned PC_W = 28
)(
   input  logic            clk,
   input  logic            rst_n,
   input  pc_act_e         act,
   input  logic [PC_W-1:0] target,
   output logic [PC_W-1:0] pc
);
   logic [PC_W-1:0] pc_nxt;

   always_comb begin
      unique case (act)
         PC_STEP: pc_nxt = pc + 1'b1;
         PC_LOAD: pc_nxt = target;
         default: pc_nxt = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= '0;
      else        pc <= pc_nxt;
   end
endmodule

// File: rtl/seq_phase.sv
module seq_phase #(
   parameter int unsigned PH_W = 2
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            advance,
   input  logic            clear,
   output logic [PH_W-1:0] phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (clear)   phase <= '0;
      else if (advance) phase <= phase + 1'b1;
   end
endmodule

// File: rtl/seq_decode.sv
module seq_decode
   import seq_pkg::*;
#(
   parameter int unsigned PC_W       = 28,
   parameter int unsigned PH_W       = 2,
   parameter bit          IMM_SIGNED = 1'b1
)(
   input  logic [INSN_W-1:0] insn,
   input  logic [PH_W-1:0]   phase,
   output logic [CTL_W-1:0]  ctl,
   output logic [IMM_W-1:0]  imm,
   output pc_act_e           pc_act,
   output logic [PC_W-1:0]   pc_target,
   output logic              ph_adv,
   output logic              ph_clr
);
   localparam int unsigned EXT_W = IMM_W - IMM_FLD;

   logic [3:0]         kind;
   logic [IMM_FLD-1:0] fld;
   logic [IMM_W-1:0]   ext;
   logic               first;

   assign kind      = insn[31:28];
   assign fld       = insn[27:4];
   assign first     = (phase == '0);
   assign pc_target = insn[PC_W-1:0];

   generate
      if (IMM_SIGNED) begin : g_sext
         assign ext = {{EXT_W{fld[IMM_FLD-1]}}, fld};
      end else begin : g_zext
         assign ext = {{EXT_W{1'b0}}, fld};
      end
   endgenerate

   always_comb begin
      ctl    = '0;
      imm    = '0;
      pc_act = PC_STEP;
      ph_adv = 1'b0;
      ph_clr = 1'b0;
      case (kind)
         K_EXEC: ctl = insn[CTL_W-1:0];
         K_LDI: begin
            imm = ext;
            ctl = pack_ctl(OP_PASS_A, SRC_IMM, SRC_NONE, insn[3:0]);
         end
         K_LOAD: begin
            if (first) begin
               ctl    = pack_ctl(OP_PASS_A, insn[11:8], SRC_NONE, DST_ADDR);
               pc_act = PC_HOLD;
               ph_adv = 1'b1;
            end else begin
               ctl    = pack_ctl(OP_PASS_A, SRC_MEM, SRC_NONE, insn[3:0]);
               ph_clr = 1'b1;
            end
         end
         K_STORE: begin
            if (first) begin
               ctl    = pack_ctl(OP_PASS_B, SRC_NONE, insn[7:4], DST_ADDR);
               pc_act = PC_HOLD;
               ph_adv = 1'b1;
            end else begin
               ctl    = pack_ctl(OP_PASS_A, insn[11:8], SRC_NONE, DST_DATA);
               ph_clr = 1'b1;
            end
         end
         K_JUMP:  pc_act = PC_LOAD;
         default: ;
      endcase
   end
endmodule

// File: rtl/instr_sequencer.sv
module instr_sequencer
   import seq_pkg::*;
#(
   parameter int unsigned PC_W       = 28,
   parameter int unsigned PH_W       = 2,
   parameter bit          IMM_SIGNED = 1'b1
)(
   input  logic            clk,
   input  logic            rst_n,
   output logic [PC_W-1:0] fetch_pc,
   input  logic [31:0]     fetch_word,
   output logic [15:0]     ctl_word,
   output logic [31:0]     imm_out
);
   generate
      if (PC_W < 1 || PC_W > 28) begin : g_bad_pc
         $error("instr_sequencer: PC_W must lie in 1..28");
      end
      if (PH_W < 1) begin : g_bad_ph
         $error("instr_sequencer: PH_W must be at least 1");
      end
   endgenerate

   logic [PH_W-1:0]  phase;
   logic [CTL_W-1:0] dec_ctl;
   logic [IMM_W-1:0] dec_imm;
   pc_act_e          pc_act;
   logic [PC_W-1:0]  pc_target;
   logic             ph_adv, ph_clr;

   seq_decode #(.PC_W(PC_W), .PH_W(PH_W), .IMM_SIGNED(IMM_SIGNED)) u_dec (
      .insn(fetch_word), .phase(phase), .ctl(dec_ctl), .imm(dec_imm),
      .pc_act(pc_act), .pc_target(pc_target), .ph_adv(ph_adv), .ph_clr(ph_clr)
   );

   seq_pc #(.PC_W(PC_W)) u_pc (
      .clk(clk), .rst_n(rst_n), .act(pc_act), .target(pc_target), .pc(fetch_pc)
   );

   seq_phase #(.PH_W(PH_W)) u_phase (
      .clk(clk), .rst_n(rst_n), .advance(ph_adv), .clear(ph_clr), .phase(phase)
   );

   assign ctl_word = rst_n ? dec_ctl : '0;
   assign imm_out  = rst_n ? dec_imm : '0;
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
   parameter int unsigned PC_W = 28
)(
   input logic            clk,
   input logic            rst_n,
   input logic [PC_W-1:0] fetch_pc,
   input logic [31:0]     fetch_word,
   input logic [15:0]     ctl_word
);
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> (ctl_word == 16'h0 && fetch_pc == '0));

   a_r2_exec_steps: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_word[31:28] == 4'h0 |=> fetch_pc == $past(fetch_pc) + 1'b1);

   a_r4_store_holds_pc: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_word[31:28] == 4'h3 && ctl_word[3:0] == 4'hC) |=> $stable(fetch_pc));

   a_r5_addr_then_data: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_word[3:0] == 4'hC && (fetch_word[31:28] == 4'h2 || fetch_word[31:28] == 4'h3))
      |=> (ctl_word[3:0] == 4'hD || ctl_word[11:8] == 4'hD));

   a_r6_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_word[31:28] == 4'hF |=> fetch_pc == $past(fetch_word[PC_W-1:0]));

   a_r7_undef_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_word[31:28] inside {[4'h4:4'hE]}) |-> ctl_word == 16'h0);
endmodule

bind instr_sequencer seq_checker #(.PC_W(PC_W)) u_seq_checker (
   .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc),
   .fetch_word(fetch_word), .ctl_word(ctl_word)
);

// File: tb/test_instr_sequencer.sv
module test_instr_sequencer;
   localparam int PC_W = 28;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [PC_W-1:0] fetch_pc;
   logic [31:0]     fetch_word;
   logic [15:0]     ctl_word;
   logic [31:0]     imm_out;
   logic [31:0]     prog [16];

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   assign fetch_word = (fetch_pc < 16) ? prog[fetch_pc[3:0]] : 32'h0;

   instr_sequencer #(.PC_W(PC_W)) i_instr_sequencer (
      .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_word(fetch_word),
      .ctl_word(ctl_word), .imm_out(imm_out)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic restart(input logic [31:0] w0, input logic [31:0] w1,
                          input logic [31:0] w2, input logic [31:0] w3);
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < 16; i++) prog[i] = 32'h7000_0000;
      prog[0] = w0; prog[1] = w1; prog[2] = w2; prog[3] = w3;
      @(negedge clk);
      rst_n = 1'b1;
      #1;
   endtask

   task automatic t_reset();
      @(negedge clk);
      rst_n = 1'b0;
      prog[0] = 32'h0000_51F2;
      #1;
      check("R1 ctl in reset", {16'h0, ctl_word}, 32'h0);
      check("R1 imm in reset", imm_out, 32'h0);
      check("R1 pc in reset", {4'h0, fetch_pc}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      check("R1 first word after reset", {16'h0, ctl_word}, 32'h51F2);
   endtask

   task automatic t_exec_imm();
      restart(32'h0000_51F2, 32'h1FFF_FFA1, 32'h1000_0123, 32'h7000_0000);
      check("R2 ctl passthrough", {16'h0, ctl_word}, 32'h51F2);
      check("R2 imm zero", imm_out, 32'h0);
      @(negedge clk); #1;
      check("R2 pc step", {4'h0, fetch_pc}, 32'h1);
      check("R3 ctl negative imm", {16'h0, ctl_word}, 32'hAB01);
      check("R3 imm sign extend", imm_out, 32'hFFFF_FFFA);
      @(negedge clk); #1;
      check("R3 pc step", {4'h0, fetch_pc}, 32'h2);
      check("R3 ctl positive imm", {16'h0, ctl_word}, 32'hAB03);
      check("R3 imm positive", imm_out, 32'h0000_0012);
      @(negedge clk); #1;
      check("R3 pc after", {4'h0, fetch_pc}, 32'h3);
   endtask

   task automatic t_store_load();
      restart(32'h3000_0110, 32'h2000_0503, 32'hF000_0000, 32'h7000_0000);
      check("R4 store phase 0 ctl", {16'h0, ctl_word}, 32'hB01C);
      @(negedge clk); #1;
      check("R4 store holds pc", {4'h0, fetch_pc}, 32'h0);
      check("R4 store phase 1 ctl", {16'h0, ctl_word}, 32'hA10D);
      @(negedge clk); #1;
      check("R5 pc after store", {4'h0, fetch_pc}, 32'h1);
      check("R5 load phase 0 ctl", {16'h0, ctl_word}, 32'hA50C);
      @(negedge clk); #1;
      check("R5 load holds pc", {4'h0, fetch_pc}, 32'h1);
      check("R5 load phase 1 ctl", {16'h0, ctl_word}, 32'hAD03);
      @(negedge clk); #1;
      check("R5 pc after load", {4'h0, fetch_pc}, 32'h2);
      check("R6 jump ctl zero", {16'h0, ctl_word}, 32'h0);
      @(negedge clk); #1;
      check("R6 jump to 0", {4'h0, fetch_pc}, 32'h0);
      check("R4 store restarts at phase 0", {16'h0, ctl_word}, 32'hB01C);
   endtask

   task automatic t_jump_undef();
      restart(32'hF000_000A, 32'h7000_0000, 32'h7000_0000, 32'h7000_0000);
      check("R6 ctl zero", {16'h0, ctl_word}, 32'h0);
      @(negedge clk); #1;
      check("R6 pc target", {4'h0, fetch_pc}, 32'hA);
      restart(32'h7ABC_DEF5, 32'hE123_4567, 32'h7000_0000, 32'h7000_0000);
      check("R7 undefined ctl", {16'h0, ctl_word}, 32'h0);
      check("R7 undefined imm", imm_out, 32'h0);
      @(negedge clk); #1;
      check("R7 pc step", {4'h0, fetch_pc}, 32'h1);
      check("R7 second undefined ctl", {16'h0, ctl_word}, 32'h0);
   endtask

   task automatic t_program();
      logic [31:0] rf [16];
      logic [31:0] ram [256];
      logic [7:0]  mar;
      logic [31:0] b1, b2, r;
      for (int i = 0; i < 16; i++) rf[i] = 32'h0;
      for (int i = 0; i < 256; i++) ram[i] = 32'h0;
      mar = 8'h0;
      restart(32'h1FFF_FFF9, 32'h1FFF_FFA1, 32'h3000_0110, 32'h2000_0103);
      prog[4] = 32'h0000_51F2;
      prog[5] = 32'h0000_A201;
      prog[6] = 32'hF000_0002;
      for (int c = 0; c < 2 + 7 * 16; c++) begin
         case (ctl_word[11:8])
            4'hB:    b1 = imm_out;
            4'hD:    b1 = ram[mar];
            default: b1 = (ctl_word[11:8] inside {[1:9]}) ? rf[ctl_word[11:8]] : 32'h0;
         endcase
         if (ctl_word[7:4] == 4'hF) b2 = 32'h1;
         else b2 = (ctl_word[7:4] inside {[1:9]}) ? rf[ctl_word[7:4]] : 32'h0;
         case (ctl_word[15:12])
            4'h0: r = b1 & b2;
            4'h1: r = b1 | b2;
            4'h2: r = b1 ^ b2;
            4'h5: r = b1 + b2;
            4'h6: r = b1 - b2;
            4'hA: r = b1;
            4'hB: r = b2;
            default: r = 32'h0;
         endcase
         if (ctl_word[3:0] inside {[1:9]}) rf[ctl_word[3:0]] = r;
         else if (ctl_word[3:0] == 4'hC) mar = r[7:0];
         else if (ctl_word[3:0] == 4'hD) ram[mar] = r;
         @(negedge clk); #1;
      end
      for (int k = -6; k < 10; k++) begin
         logic [31:0] kv;
         kv = k;
         check("R8 loop store", ram[kv[7:0]], kv);
      end
      check("R8 load copies last store", rf[3], 32'd9);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) prog[i] = 32'h0;
      t_reset();
      t_exec_imm();
      t_store_load();
      t_jump_undef();
      t_program();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule